// File: doc/BRIEF.md
# Hysteretic Threshold Monitor with Change Interrupt

This block compares a digitized analog quantity, such as a supply voltage code or a die temperature code, against two programmable levels. It keeps an alarm status bit with hysteresis. The status bit enters the alarm state when the measurement crosses the "on" level. It leaves the alarm state only when the measurement crosses back past a separate "off" level. Between the two levels the bit keeps its last value, so a noisy measurement near one level does not make the status bit toggle.

Any change of the status bit sets a sticky event flag. This covers both entering and leaving the alarm state. Software clears the flag with a write-one-to-clear strobe. The interrupt request is the flag gated by an enable. The bit is evaluated only while the monitor-active input is high, which means the device is in its full-performance mode, and only on cycles that carry a valid sample.

A compile-time polarity parameter picks the comparison direction. With below-is-alarm polarity the block acts as an undervoltage monitor. With above-is-alarm polarity it acts as an overtemperature monitor. One instance of each polarity covers both uses.

Top module: `hyst_mon`

## Requirements
- R1: After reset, `alarm_o`, `flag_o` and `irq_o` are 0.
- R2: With `ALARM_BELOW`=1, a sample evaluated at a clock edge with `smp_val` strictly less than `lvl_on` sets `alarm_o` to 1 at that edge.
- R3: With `ALARM_BELOW`=1, an evaluated sample strictly greater than `lvl_off` clears `alarm_o` to 0 at that edge. Here `lvl_off` is greater than `lvl_on`.
- R4: An evaluated sample that lies between the two levels leaves `alarm_o` unchanged. A sample equal to either level counts as lying between them.
- R5: A sample is evaluated only when `mon_active` and `smp_vld` are both 1. On any other cycle `alarm_o` holds its value, whatever `smp_val` is.
- R6: `flag_o` becomes 1 at the same edge where `alarm_o` changes, in either direction. When `alarm_o` does not change, a cleared flag stays 0.
- R7: `flag_o` stays set until a cycle with `flag_clr`=1, which clears it at that edge. If a status change happens at the same edge as the clear, the flag ends up set.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en` is 1.
- R9: With `ALARM_BELOW`=0, an evaluated sample strictly greater than `lvl_on` sets `alarm_o`. A sample strictly less than `lvl_off` clears it, with `lvl_off` below `lvl_on`. Samples in between, or equal to a level, hold it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_active | input | 1 | High while the device is in full-performance mode; enables monitoring |
| smp_vld | input | 1 | Measurement word is valid this cycle |
| smp_val | input | DATA_W | Measurement code |
| lvl_on | input | DATA_W | Level whose crossing enters the alarm state |
| lvl_off | input | DATA_W | Level whose crossing leaves the alarm state |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the event flag |
| alarm_o | output | 1 | Hysteresis-filtered alarm status |
| flag_o | output | 1 | Sticky status-change event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the two levels are ordered as the polarity requires, so that no single sample can satisfy both the "on" and the "off" comparison. They also assume the levels stay stable while samples are evaluated. The bench programs fixed, correctly ordered levels for each instance and changes them only under reset. The vector table steps the measurement across both levels, onto each level exactly, and through idle and non-valid cycles. It times flag clears both alone and together with a status change.

// File: rtl/hyst_mon_pkg.sv
package hyst_mon_pkg;

  // True when value v lies strictly past level lvl in the given direction.
  function automatic logic hm_beyond(input logic [31:0] v,
                                     input logic [31:0] lvl,
                                     input logic        upward);
    return upward ? (v > lvl) : (v < lvl);
  endfunction

endpackage

// File: rtl/hm_cmp.sv
module hm_cmp #(
  parameter int DATA_W      = 10,
  parameter bit ALARM_BELOW = 1'b1
) (
  input  logic [DATA_W-1:0] smp_val,
  input  logic [DATA_W-1:0] lvl_on,
  input  logic [DATA_W-1:0] lvl_off,
  output logic              hit_on,
  output logic              hit_off
);
  import hyst_mon_pkg::*;

  localparam int EXT_W = 32;

  logic on_up;
  generate
    if (ALARM_BELOW) begin : g_below
      assign on_up = 1'b0;   // alarm when falling below lvl_on
    end else begin : g_above
      assign on_up = 1'b1;   // alarm when rising above lvl_on
    end
  endgenerate

  always_comb begin
    hit_on  = hm_beyond(EXT_W'(smp_val), EXT_W'(lvl_on),  on_up);
    hit_off = hm_beyond(EXT_W'(smp_val), EXT_W'(lvl_off), !on_up);
  end

endmodule

// File: rtl/hm_state.sv
module hm_state (
  input  logic clk,
  input  logic rst_n,
  input  logic eval,
  input  logic hit_on,
  input  logic hit_off,
  output logic alarm_q,
  output logic stat_chg
);

  logic alarm_nxt;

  always_comb begin
    alarm_nxt = alarm_q;
    if (eval) begin
      if (hit_on)       alarm_nxt = 1'b1;
      else if (hit_off) alarm_nxt = 1'b0;
    end
  end

  assign stat_chg = alarm_nxt ^ alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= alarm_nxt;
  end

  AST_ALARM_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && hit_on) |=> alarm_q);                                // R2
  AST_ALARM_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && hit_off && !hit_on) |=> !alarm_q);                   // R3
  AST_ALARM_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !hit_on && !hit_off) |=> $stable(alarm_q));          // R4
  AST_ALARM_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(alarm_q));                                  // R5

endmodule

// File: rtl/hm_flag.sv
module hm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_chg,
  input  logic flag_clr,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (stat_chg) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_chg |=> flag_q);                                         // R6
  AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !stat_chg) |=> !flag_q);                          // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);                            // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !stat_chg) |=> !flag_q);                         // R7

endmodule

// File: rtl/hyst_mon.sv
module hyst_mon #(
  parameter int DATA_W      = 10,
  parameter bit ALARM_BELOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_active,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_val,
  input  logic [DATA_W-1:0] lvl_on,
  input  logic [DATA_W-1:0] lvl_off,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              alarm_o,
  output logic              flag_o,
  output logic              irq_o
);

  logic eval;
  logic hit_on;
  logic hit_off;
  logic stat_chg;

  assign eval = mon_active & smp_vld;

  hm_cmp #(.DATA_W(DATA_W), .ALARM_BELOW(ALARM_BELOW)) u_cmp (
    .smp_val (smp_val),
    .lvl_on  (lvl_on),
    .lvl_off (lvl_off),
    .hit_on  (hit_on),
    .hit_off (hit_off)
  );

  hm_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .eval     (eval),
    .hit_on   (hit_on),
    .hit_off  (hit_off),
    .alarm_q  (alarm_o),
    .stat_chg (stat_chg)
  );

  hm_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_chg (stat_chg),
    .flag_clr (flag_clr),
    .flag_q   (flag_o)
  );

  assign irq_o = flag_o & irq_en;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_en && flag_o));                                // R8
  AST_LEVELS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    eval |-> !(hit_on && hit_off));                               // R9

endmodule

// File: tb/tb_hyst_mon.sv
module tb_hyst_mon;

  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mon_active = 1'b0;
  logic          smp_vld = 1'b0;
  logic [DW-1:0] smp_val = '0;
  logic          irq_en = 1'b1;
  logic          flag_clr = 1'b0;
  logic          alarm_lo, flag_lo, irq_lo;
  logic          alarm_hi, flag_hi, irq_hi;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  hyst_mon #(.DATA_W(DW), .ALARM_BELOW(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .mon_active(mon_active), .smp_vld(smp_vld),
    .smp_val(smp_val), .lvl_on(10'd100), .lvl_off(10'd120), .irq_en(irq_en),
    .flag_clr(flag_clr), .alarm_o(alarm_lo), .flag_o(flag_lo), .irq_o(irq_lo));

  hyst_mon #(.DATA_W(DW), .ALARM_BELOW(1'b0)) dut_hi (
    .clk(clk), .rst_n(rst_n), .mon_active(mon_active), .smp_vld(smp_vld),
    .smp_val(smp_val), .lvl_on(10'd200), .lvl_off(10'd180), .irq_en(irq_en),
    .flag_clr(flag_clr), .alarm_o(alarm_hi), .flag_o(flag_hi), .irq_o(irq_hi));

  typedef struct packed {
    logic          mon;
    logic          vld;
    logic [DW-1:0] val;
    logic          clr;
    logic          st;
    logic          fl;
  } vec_t;

  localparam int NV = 12;
  // below-is-alarm instance, on=100, off=120, irq_en=1
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 10'd150, 1'b0, 1'b0, 1'b0},  // R3 above off: stays 0
    '{1'b1, 1'b1, 10'd90,  1'b0, 1'b1, 1'b1},  // R2 R6 enter alarm
    '{1'b1, 1'b1, 10'd110, 1'b1, 1'b1, 1'b0},  // R4 band hold, R7 clear
    '{1'b1, 1'b1, 10'd120, 1'b0, 1'b1, 1'b0},  // R4 equal off level holds
    '{1'b1, 1'b1, 10'd100, 1'b0, 1'b1, 1'b0},  // R4 equal on level holds
    '{1'b0, 1'b1, 10'd500, 1'b0, 1'b1, 1'b0},  // R5 monitor inactive
    '{1'b1, 1'b0, 10'd500, 1'b0, 1'b1, 1'b0},  // R5 sample not valid
    '{1'b1, 1'b1, 10'd121, 1'b0, 1'b0, 1'b1},  // R3 R6 leave alarm
    '{1'b1, 1'b1, 10'd99,  1'b1, 1'b1, 1'b1},  // R7 set wins over clear
    '{1'b1, 1'b1, 10'd130, 1'b0, 1'b0, 1'b1},  // R3 leave again
    '{1'b1, 1'b1, 10'd110, 1'b1, 1'b0, 1'b0},  // R7 clear
    '{1'b1, 1'b1, 10'd0,   1'b0, 1'b1, 1'b1}   // R2 minimum code
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, return at the next negedge.
  task automatic step(input logic m, input logic v, input logic [DW-1:0] x,
                      input logic c);
    mon_active = m; smp_vld = v; smp_val = x; flag_clr = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mon_active = 1'b0; smp_vld = 1'b0; flag_clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 alarm", alarm_lo, 1'b0);
    chk("R1 flag",  flag_lo,  1'b0);
    chk("R1 irq",   irq_lo,   1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].mon, VEC[i].vld, VEC[i].val, VEC[i].clr);
      chk($sformatf("R2-table row %0d alarm", i), alarm_lo, VEC[i].st);
      chk($sformatf("R6-table row %0d flag", i), flag_lo, VEC[i].fl);
      chk($sformatf("R8 row %0d irq", i), irq_lo, VEC[i].fl);
    end

    // R8: flag set, enable low masks the request
    irq_en = 1'b0;
    #1;
    chk("R8 masked irq", irq_lo, 1'b0);
    chk("R8 flag kept",  flag_lo, 1'b1);
    irq_en = 1'b1;
    #1;
    chk("R8 unmasked irq", irq_lo, 1'b1);

    // R7: flag held with no clear across non-evaluated cycles
    step(1'b0, 1'b0, 10'd300, 1'b0);
    step(1'b0, 1'b0, 10'd300, 1'b0);
    chk("R7 sticky", flag_lo, 1'b1);

    // R1: reset with alarm and flag set
    do_reset();
    chk("R1 re-reset alarm", alarm_lo, 1'b0);
    chk("R1 re-reset flag",  flag_lo,  1'b0);

    // R9: above-is-alarm instance, on=200, off=180
    step(1'b1, 1'b1, 10'd200, 1'b0);
    chk("R9 equal on holds 0", alarm_hi, 1'b0);
    chk("R9 no flag", flag_hi, 1'b0);
    step(1'b1, 1'b1, 10'd201, 1'b0);
    chk("R9 enter", alarm_hi, 1'b1);
    chk("R9 flag on enter", flag_hi, 1'b1);
    step(1'b1, 1'b1, 10'd190, 1'b1);
    chk("R9 band hold", alarm_hi, 1'b1);
    chk("R9 flag cleared", flag_hi, 1'b0);
    step(1'b1, 1'b1, 10'd180, 1'b0);
    chk("R9 equal off holds", alarm_hi, 1'b1);
    step(1'b1, 1'b1, 10'd179, 1'b0);
    chk("R9 leave", alarm_hi, 1'b0);
    chk("R9 flag on leave", flag_hi, 1'b1);
    chk("R9 irq", irq_hi, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule